// File: doc/BRIEF.md
# Chained-Channel Successive-Approximation Converter Controller

This block is the digital sequencer for a 12-bit successive-approximation converter with eight analog inputs. Software selects a set of inputs through a channel-select register, picks single-pass or repeating operation, and sets a go bit. The controller then visits the selected inputs from the lowest index to the highest. For each input it runs a fixed sample, transfer, bit-decision and data phase, and it stores the result with a valid flag in that input's result register. It also raises a per-input done flag and, after the last input, a single chain-finished flag that can drive an interrupt line.

The analog comparator and the trial-code DAC sit outside the block. The controller drives the trial code on `sar_dac_code` and the index of the input it is converting on `conv_ch`. The environment answers on `sar_cmp` with 1 when the input is at or above the trial code. A per-input DMA request pulse can accompany each result update. Clearing the go bit never cuts a chain short.

Top module: `sarc_chain_ctrl`

## Requirements
- R1: After reset, the configuration word at 0x000 reads 0x00003901, so power-down is set. The sample-time register at 0x094 reads 0x14. The channel-select register, done flags, chain flag and `irq` are all zero, and no result is valid.
- R2: The result register of input n is at 0x100+4n, with the code in bits 11:0 and valid in bit 19. The code is decided most significant bit first in 12 decisions: a trial bit is kept when `sar_cmp` is 1. With `sar_cmp` = (input >= `sar_dac_code`), the stored code equals the input level, including 0 and 4095.
- R3: Only the inputs selected in bits 7:0 of 0x0A4 are converted, each once per chain, in ascending index order. Bits 31:8 of that register read as zero. The selection is captured when a chain begins.
- R4: One conversion lasts S+60 clocks, where S is the effective sample time. With the block already powered, the first result becomes visible S+61 clocks after the clock edge that accepts the go write.
- R5: The sample-time register at 0x094 is 8 bits wide and reads back what was written. Any value below 8 acts as 8.
- R6: Bit n of the done-flag register at 0x014 sets when input n's result is stored, and writing 1 to the bit clears it.
- R7: Bit 0 of 0x010 sets when the last selected input of a chain is stored, and writing 1 clears it. `irq` equals that bit ANDed with bit 0 of 0x020.
- R8: With mode bit 29 at 0, a go (bit 24) runs exactly one chain, and bit 24 reads 0 once the chain has ended.
- R9: With mode bit 29 at 1, a new chain starts on the clock after a chain ends, for as long as bit 24 stays set. Results are then spaced exactly S+60 clocks apart. Clearing bit 24 during a chain lets that chain finish, and no further chain starts.
- R10: While bit 0 (power-down) is set, no chain starts. After bit 0 is cleared, a pending go is held for 3 clocks, so a single write that clears power-down and sets go yields the first result S+64 clocks after its edge.
- R11: A read strobe on a result register clears that input's valid bit and leaves its code unchanged.
- R12: When bit 0 of 0x040 and bit n of 0x044 are both set, `dma_req[n]` pulses for one clock with each store of input n. When bit n of 0x044 is clear, there is no pulse.
- R13: A go with an empty channel selection starts no chain and raises no chain flag. In single-pass mode, bit 24 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect: clears result valid) |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| sar_cmp | input | 1 | Comparator decision: 1 when the input is at or above the trial code |
| sar_dac_code | output | 12 | Trial code presented to the DAC |
| conv_ch | output | 3 | Index of the input being converted |
| conv_busy | output | 1 | A chain is in progress |
| irq | output | 1 | Masked chain-finished interrupt |
| dma_req | output | 8 | Per-input DMA request pulses |

## Verification
The bench models the analog side by comparing a per-input level with the trial code. It then checks stored codes across many channel selections, including the 0 and full-scale levels that a wrong bit-decision order or an off-by-one step count would corrupt. It measures the cycle distance from go to the first done flag across sample times below, at and above the floor, and after a power-up. A missing clamp, a wrong phase length or a lost warm-up hold each shifts that distance. In repeating mode it times the spacing between successive results to catch an idle gap between chains, and it clears go in mid-chain to catch a design that aborts the chain or keeps running. Empty selections, masked DMA and read-to-clear are checked at the register port.

// File: rtl/sarc_pkg.sv
// Shared constants for the chained-channel SAR controller: register offsets,
// bit positions inside the configuration word, phase lengths and the phase type.
package sarc_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CFG        = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CHAIN_STAT = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_DONE_FLAGS = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_CHAIN_IE   = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_DMA_EN     = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_DMA_SEL    = 12'h044;
    localparam logic [ADDR_W-1:0] OFS_SAMP_TIME  = 12'h094;
    localparam logic [ADDR_W-1:0] OFS_CH_SELECT  = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFS_RESULT0    = 12'h100;

    localparam int CFG_PWDN_BIT  = 0;
    localparam int CFG_GO_BIT    = 24;
    localparam int CFG_MODE_BIT  = 29;
    localparam int VALID_BIT     = 19;

    localparam logic [DATA_W-1:0] CFG_RESET  = 32'h0000_3901;
    localparam logic [7:0]        SAMP_RESET = 8'h14;

    localparam int SAMP_FLOOR   = 8;
    localparam int WARM_CYCLES  = 3;
    localparam int XFER_CYCLES  = 2;
    localparam int DATA_CYCLES  = 2;
    localparam int STEP_CYCLES  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_XFER,
        PH_CONV,
        PH_DATA
    } sarc_phase_e;
endpackage

// File: rtl/sarc_sar.sv
// Successive-approximation register. On load it presents mid-scale as the
// first trial. On each decision strobe it keeps or drops the bit under test,
// based on the comparator, and raises the next lower trial bit.
// Assumes strobes for steps 0..RES-1 arrive in order after a load.
module sarc_sar #(
    parameter int RES    = 12,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              strobe,
    input  logic [STEP_W-1:0] step,
    input  logic              cmp,
    output logic [RES-1:0]    code
);
    logic [RES-1:0] code_nxt;

    // Next trial code: the decided bit takes the comparator value, the one below turns on.
    always_comb begin
        code_nxt = code;
        for (int k = 0; k < RES; k++) begin
            if (int'(step) == RES - 1 - k) code_nxt[k] = cmp;
            if (int'(step) == RES - 2 - k) code_nxt[k] = 1'b1;
        end
    end

    // Code register: mid-scale on load, refined on each decision strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      code <= '0;
        else if (load)   code <= {1'b1, {(RES-1){1'b0}}};
        else if (strobe) code <= code_nxt;
    end

    // R2: the first decision always starts from a mid-scale trial.
    a_r2_load_midscale: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (code[RES-1] && (code[RES-2:0] == '0)));
endmodule

// File: rtl/sarc_sequencer.sv
// Chain sequencer. It captures the channel selection when a chain begins and
// walks the selected inputs in ascending order. For each input it times the
// sample, transfer, bit-step and data phases, and it emits one pulse per
// stored result and one per finished chain. Assumes samp_cyc is already
// clamped to the floor.
module sarc_sequencer import sarc_pkg::*; #(
    parameter int NCH    = 8,
    parameter int RES    = 12,
    parameter int SAMP_W = 8,
    parameter int STEP_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go,
    input  logic                     cont_req,
    input  logic [NCH-1:0]           chan_mask,
    input  logic [SAMP_W-1:0]        samp_cyc,
    output logic                     busy,
    output logic [$clog2(NCH)-1:0]   cur_ch,
    output logic                     sar_load,
    output logic                     sar_strobe,
    output logic [STEP_W-1:0]        sar_step,
    output logic                     conv_done,
    output logic                     chain_done
);
    localparam int CH_W     = $clog2(NCH);
    localparam int CONV_CYC = (RES + 2) * STEP_CYCLES;
    localparam int CONV_W   = $clog2(CONV_CYC);
    localparam int CNT_W    = (SAMP_W + 1 > CONV_W) ? SAMP_W + 1 : CONV_W;
    localparam int STEP_SH  = $clog2(STEP_CYCLES);

    sarc_phase_e      phase;
    logic [CNT_W-1:0] cnt;
    logic [NCH-1:0]   snap;
    logic [SAMP_W-1:0] samp_lat;
    logic [CH_W-1:0]  first_ch;
    logic [CH_W-1:0]  next_ch;
    logic             has_next;
    logic             last_tick;
    logic             relaunch;

    // Lowest selected input of the live selection, used when a chain begins.
    always_comb begin
        first_ch = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (chan_mask[i]) first_ch = CH_W'(i);
    end

    // Next selected input above the current one in the captured selection.
    always_comb begin
        has_next = 1'b0;
        next_ch  = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (snap[i] && (i > int'(cur_ch))) begin
                has_next = 1'b1;
                next_ch  = CH_W'(i);
            end
    end

    // Final cycle of the current phase.
    always_comb begin
        case (phase)
            PH_SAMPLE: last_tick = (cnt == CNT_W'(samp_lat) - CNT_W'(1));
            PH_XFER:   last_tick = (cnt == CNT_W'(XFER_CYCLES - 1));
            PH_CONV:   last_tick = (cnt == CNT_W'(CONV_CYC - 1));
            PH_DATA:   last_tick = (cnt == CNT_W'(DATA_CYCLES - 1));
            default:   last_tick = 1'b0;
        endcase
    end

    assign busy       = (phase != PH_IDLE);
    assign conv_done  = (phase == PH_DATA) && last_tick;
    assign chain_done = conv_done && !has_next;
    assign relaunch   = chain_done && cont_req && (|chan_mask);
    assign sar_load   = (phase == PH_XFER) && last_tick;
    assign sar_step   = STEP_W'(cnt >> STEP_SH);
    assign sar_strobe = (phase == PH_CONV) && (&cnt[STEP_SH-1:0]) && (sar_step < STEP_W'(RES));

    // Phase machine: launch, per-phase counting, advance to next input or next chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            snap     <= '0;
            cur_ch   <= '0;
            samp_lat <= SAMP_W'(SAMP_FLOOR);
        end else if (phase == PH_IDLE) begin
            if (go && (|chan_mask)) begin
                snap     <= chan_mask;
                cur_ch   <= first_ch;
                samp_lat <= samp_cyc;
                phase    <= PH_SAMPLE;
                cnt      <= '0;
            end
        end else if (!last_tick) begin
            cnt <= cnt + CNT_W'(1);
        end else begin
            cnt <= '0;
            case (phase)
                PH_SAMPLE: phase <= PH_XFER;
                PH_XFER:   phase <= PH_CONV;
                PH_CONV:   phase <= PH_DATA;
                default: begin
                    if (has_next) begin
                        cur_ch <= next_ch;
                        phase  <= PH_SAMPLE;
                    end else if (relaunch) begin
                        snap     <= chan_mask;
                        cur_ch   <= first_ch;
                        samp_lat <= samp_cyc;
                        phase    <= PH_SAMPLE;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
            endcase
        end
    end

    // R4: a sample phase never runs shorter than the floor.
    a_r4_samp_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SAMPLE) |-> (samp_lat >= SAMP_W'(SAMP_FLOOR)));

    // R3: within a chain each following input has a higher index.
    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && has_next) |=> (cur_ch > $past(cur_ch)));

    // R9: repeating mode starts the next chain on the following clock.
    a_r9_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        relaunch |=> (phase == PH_SAMPLE));

    // R8: without a repeat request the sequencer goes idle after the chain.
    a_r8_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_done && !cont_req) |=> !busy);
endmodule

// File: rtl/sarc_regs.sv
// Register file of the controller. It holds configuration, sample time,
// channel selection, interrupt and DMA enables, the write-1-to-clear flags
// and the per-input result registers. Reads are combinational on the
// address; a read strobe on a result clears its valid bit. Assumes at most
// one result store per clock.
module sarc_regs import sarc_pkg::*; #(
    parameter int NCH    = 8,
    parameter int RES    = 12,
    parameter int SAMP_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic                   conv_done,
    input  logic [$clog2(NCH)-1:0] conv_ch,
    input  logic [RES-1:0]         conv_code,
    input  logic                   chain_done,
    output logic                   pwdn,
    output logic                   go_bit,
    output logic                   cont_mode,
    output logic                   warm_busy,
    output logic [NCH-1:0]         chan_mask,
    output logic [SAMP_W-1:0]      samp_eff,
    output logic                   irq,
    output logic [NCH-1:0]         dma_req
);
    localparam int CH_W   = $clog2(NCH);
    localparam int WARM_W = $clog2(WARM_CYCLES + 1);
    localparam logic [ADDR_W-1:0] RESULT_END = OFS_RESULT0 + ADDR_W'(4 * NCH);

    logic [DATA_W-1:0] cfg;
    logic [SAMP_W-1:0] samp_raw;
    logic [NCH-1:0]    ch_sel;
    logic [NCH-1:0]    dma_sel;
    logic              dma_en;
    logic              chain_ie;
    logic              chain_stat;
    logic [WARM_W-1:0] warm_cnt;
    logic [NCH-1:0]    done_flags;
    logic [NCH-1:0]    valid;
    logic [RES-1:0]    result [NCH];

    logic              wr_cfg, wr_stat, wr_flags;
    logic              res_hit;
    logic [CH_W-1:0]   res_idx;

    assign wr_cfg   = reg_wr && (reg_addr == OFS_CFG);
    assign wr_stat  = reg_wr && (reg_addr == OFS_CHAIN_STAT);
    assign wr_flags = reg_wr && (reg_addr == OFS_DONE_FLAGS);
    assign res_hit  = (reg_addr >= OFS_RESULT0) && (reg_addr < RESULT_END) && (reg_addr[1:0] == 2'b00);
    assign res_idx  = CH_W'((reg_addr - OFS_RESULT0) >> 2);

    assign pwdn      = cfg[CFG_PWDN_BIT];
    assign go_bit    = cfg[CFG_GO_BIT];
    assign cont_mode = cfg[CFG_MODE_BIT];
    assign warm_busy = (warm_cnt != '0);
    assign chan_mask = ch_sel;
    assign samp_eff  = (samp_raw < SAMP_W'(SAMP_FLOOR)) ? SAMP_W'(SAMP_FLOOR) : samp_raw;
    assign irq       = chain_stat && chain_ie;

    // Configuration word: software writes win; single-pass go self-clears at chain end.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cfg <= CFG_RESET;
        else if (wr_cfg)                     cfg <= reg_wdata;
        else if (chain_done && !cont_mode)   cfg[CFG_GO_BIT] <= 1'b0;
    end

    // Warm-up window counter, armed when power-down is released.
    always_ff @(posedge clk) begin
        if (!rst_n)                                            warm_cnt <= '0;
        else if (wr_cfg && pwdn && !reg_wdata[CFG_PWDN_BIT])   warm_cnt <= WARM_W'(WARM_CYCLES);
        else if (warm_cnt != '0)                               warm_cnt <= warm_cnt - WARM_W'(1);
    end

    // Plain read/write control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_raw <= SAMP_RESET;
            ch_sel   <= '0;
            dma_sel  <= '0;
            dma_en   <= 1'b0;
            chain_ie <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_SAMP_TIME) samp_raw <= reg_wdata[SAMP_W-1:0];
            if (reg_addr == OFS_CH_SELECT) ch_sel   <= reg_wdata[NCH-1:0];
            if (reg_addr == OFS_DMA_SEL)   dma_sel  <= reg_wdata[NCH-1:0];
            if (reg_addr == OFS_DMA_EN)    dma_en   <= reg_wdata[0];
            if (reg_addr == OFS_CHAIN_IE)  chain_ie <= reg_wdata[0];
        end
    end

    // Chain-finished flag: set by the sequencer, cleared by writing 1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                       chain_stat <= 1'b0;
        else if (chain_done)              chain_stat <= 1'b1;
        else if (wr_stat && reg_wdata[0]) chain_stat <= 1'b0;
    end

    // Per-input result, valid, done flag and DMA request.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic store;
        logic flag_q, valid_q, dreq_q;
        logic [RES-1:0] data_q;

        assign store = conv_done && (conv_ch == CH_W'(i));

        // Stores the code and tracks the valid and done flags of this input.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q  <= 1'b0;
                valid_q <= 1'b0;
                data_q  <= '0;
                dreq_q  <= 1'b0;
            end else begin
                dreq_q <= store && dma_en && dma_sel[i];
                if (store) begin
                    data_q  <= conv_code;
                    valid_q <= 1'b1;
                    flag_q  <= 1'b1;
                end else begin
                    if (reg_rd && res_hit && (res_idx == CH_W'(i))) valid_q <= 1'b0;
                    if (wr_flags && reg_wdata[i])                   flag_q  <= 1'b0;
                end
            end
        end

        assign done_flags[i] = flag_q;
        assign valid[i]      = valid_q;
        assign result[i]     = data_q;
        assign dma_req[i]    = dreq_q;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CFG:        reg_rdata = cfg;
            OFS_CHAIN_STAT: reg_rdata[0] = chain_stat;
            OFS_DONE_FLAGS: reg_rdata[NCH-1:0] = done_flags;
            OFS_CHAIN_IE:   reg_rdata[0] = chain_ie;
            OFS_DMA_EN:     reg_rdata[0] = dma_en;
            OFS_DMA_SEL:    reg_rdata[NCH-1:0] = dma_sel;
            OFS_SAMP_TIME:  reg_rdata[SAMP_W-1:0] = samp_raw;
            OFS_CH_SELECT:  reg_rdata[NCH-1:0] = ch_sel;
            default: begin
                if (res_hit) begin
                    reg_rdata[RES-1:0] = result[res_idx];
                    reg_rdata[VALID_BIT] = valid[res_idx];
                end
            end
        endcase
    end

    // R6: a stored result raises its done flag.
    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> done_flags[$past(conv_ch)]);

    // R2: a stored result is marked valid.
    a_r2_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> valid[$past(conv_ch)]);

    // R7: the end of a chain raises the chain-finished flag.
    a_r7_chain_flag: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |=> chain_stat);

    // R12: a DMA request lasts one clock.
    a_r12_dma_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|dma_req) |=> (dma_req == '0));
endmodule

// File: rtl/sarc_chain_ctrl.sv
// Top of the chained-channel SAR controller. It joins the register file,
// the chain sequencer and the approximation register, and gates chain
// launch on go, power-down and the warm-up window. The comparator is
// external and is sampled on each decision strobe.
module sarc_chain_ctrl import sarc_pkg::*; #(
    parameter int NCH    = 8,
    parameter int RES    = 12,
    parameter int SAMP_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [11:0]            reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic                   sar_cmp,
    output logic [RES-1:0]         sar_dac_code,
    output logic [$clog2(NCH)-1:0] conv_ch,
    output logic                   conv_busy,
    output logic                   irq,
    output logic [NCH-1:0]         dma_req
);
    localparam int STEP_W = $clog2(RES + 2);

    logic              pwdn, go_bit, cont_mode, warm_busy;
    logic [NCH-1:0]    chan_mask;
    logic [SAMP_W-1:0] samp_eff;
    logic              go, cont_req;
    logic              sar_load, sar_strobe;
    logic [STEP_W-1:0] sar_step;
    logic              conv_done, chain_done;

    assign go       = go_bit && !pwdn && !warm_busy;
    assign cont_req = go && cont_mode;

    sarc_regs #(.NCH(NCH), .RES(RES), .SAMP_W(SAMP_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .conv_done  (conv_done),
        .conv_ch    (conv_ch),
        .conv_code  (sar_dac_code),
        .chain_done (chain_done),
        .pwdn       (pwdn),
        .go_bit     (go_bit),
        .cont_mode  (cont_mode),
        .warm_busy  (warm_busy),
        .chan_mask  (chan_mask),
        .samp_eff   (samp_eff),
        .irq        (irq),
        .dma_req    (dma_req)
    );

    sarc_sequencer #(.NCH(NCH), .RES(RES), .SAMP_W(SAMP_W), .STEP_W(STEP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .cont_req   (cont_req),
        .chan_mask  (chan_mask),
        .samp_cyc   (samp_eff),
        .busy       (conv_busy),
        .cur_ch     (conv_ch),
        .sar_load   (sar_load),
        .sar_strobe (sar_strobe),
        .sar_step   (sar_step),
        .conv_done  (conv_done),
        .chain_done (chain_done)
    );

    sarc_sar #(.RES(RES), .STEP_W(STEP_W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sar_load),
        .strobe (sar_strobe),
        .step   (sar_step),
        .cmp    (sar_cmp),
        .code   (sar_dac_code)
    );

    // R10: no chain begins while powered down.
    a_r10_pwdn_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_busy && pwdn) |=> !conv_busy);

    // R10: a pending go waits out the warm-up window.
    a_r10_warm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_busy && warm_busy) |=> !conv_busy);
endmodule

// File: tb/sarc_chain_ctrl_bench.sv
// Self-checking bench: models the analog input as a per-input level compared
// with the trial code, and checks codes, order, timing and flags at the ports.
module sarc_chain_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sar_cmp;
    logic [11:0] sar_dac_code;
    logic [2:0]  conv_ch;
    logic        conv_busy;
    logic        irq;
    logic [7:0]  dma_req;

    logic [11:0] vin [8];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int log_n = 0;
    int log_ch [64];
    int log_cyc [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sar_cmp = (vin[conv_ch] >= sar_dac_code);

    sarc_chain_ctrl u_sarc_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sar_cmp(sar_cmp), .sar_dac_code(sar_dac_code), .conv_ch(conv_ch),
        .conv_busy(conv_busy), .irq(irq), .dma_req(dma_req)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Log DMA pulses with their cycle stamp.
    always @(negedge clk) begin
        for (int i = 0; i < 8; i++)
            if (dma_req[i] && log_n < 64) begin
                log_ch[log_n]  = i;
                log_cyc[log_n] = cyc;
                log_n = log_n + 1;
            end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_strobe(input logic [11:0] a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Cycles from the accepting edge of the last write until done flag 0 sets.
    task automatic time_first(output int k);
        logic [31:0] d;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            peek(12'h014, d);
        end while (!d[0] && k < 2000);
    endtask

    task automatic wait_chain();
        logic [31:0] d;
        int n = 0;
        do begin
            @(negedge clk);
            n++;
            peek(12'h010, d);
        end while (!d[0] && n < 5000);
    endtask

    task automatic clear_flags();
        wr(12'h014, 32'hFF);
        wr(12'h010, 32'h1);
    endtask

    initial begin
        wait (cyc >= 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  m;
        int k, j, s_eff, pc;
        for (int i = 0; i < 8; i++) vin[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        peek(12'h000, d); chk("R1 cfg", d, 32'h0000_3901);
        peek(12'h094, d); chk("R1 samp", d, 32'h14);
        peek(12'h0A4, d); chk("R1 select", d, 32'h0);
        peek(12'h014, d); chk("R1 flags", d, 32'h0);
        peek(12'h010, d); chk("R1 chain", d, 32'h0);
        peek(12'h100, d); chk("R1 result", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 busy", {31'b0, conv_busy}, 32'h0);

        wr(12'h000, 32'h0000_3900);
        wr(12'h020, 32'h1);
        wr(12'h040, 32'h1);
        wr(12'h044, 32'hFF);
        wr(12'h094, 32'h8);

        // R2/R3/R6/R7/R8/R11/R12: single-pass chains over many selections
        for (int c = 0; c < 12; c++) begin
            if (c == 0)      m = 8'hFF;
            else if (c == 1) m = 8'h01;
            else if (c == 2) m = 8'h80;
            else             m = 8'((c * 37 + 11) & 8'hFF) | 8'h02;
            for (int i = 0; i < 8; i++) vin[i] = 12'((c * 523 + i * 1031 + 7) % 4096);
            if (c == 0) begin vin[0] = 12'd0; vin[7] = 12'd4095; end
            wr(12'h0A4, {24'b0, m});
            log_n = 0;
            wr(12'h000, 32'h0100_3900);
            wait_chain();
            @(negedge clk);
            pc = 0; j = 0;
            for (int i = 0; i < 8; i++) if (m[i]) begin
                chk("R3 R12 order", log_ch[j], i);
                j++; pc++;
                peek(12'h100 + 12'(4 * i), d);
                chk("R2 code", d, (32'h1 << 19) | {20'b0, vin[i]});
            end
            chk("R3 count", log_n, pc);
            peek(12'h014, d); chk("R6 flags", d, {24'b0, m});
            chk("R7 irq", {31'b0, irq}, 32'h1);
            peek(12'h000, d); chk("R8 go cleared", d, 32'h0000_3900);
            wr(12'h020, 32'h0);
            chk("R7 irq masked", {31'b0, irq}, 32'h0);
            wr(12'h020, 32'h1);
            clear_flags();
            peek(12'h014, d); chk("R6 w1c", d, 32'h0);
            peek(12'h010, d); chk("R7 w1c", d, 32'h0);
            chk("R7 irq cleared", {31'b0, irq}, 32'h0);
            for (int i = 0; i < 8; i++) if (m[i] && i == c % 8) begin
                rd_strobe(12'h100 + 12'(4 * i));
                peek(12'h100 + 12'(4 * i), d);
                chk("R11 read clears valid", d, {20'b0, vin[i]});
            end
        end

        // R12: masked DMA channel gives no pulse
        wr(12'h044, 32'h0);
        wr(12'h0A4, 32'h1);
        log_n = 0;
        wr(12'h000, 32'h0100_3900);
        wait_chain();
        repeat (2) @(negedge clk);
        chk("R12 masked dma", log_n, 0);
        clear_flags();
        wr(12'h044, 32'hFF);

        // R4/R5: sample-time sweep around the floor
        for (int t = 0; t < 6; t++) begin
            int sv;
            case (t)
                0: sv = 0; 1: sv = 7; 2: sv = 8; 3: sv = 9; 4: sv = 20; default: sv = 255;
            endcase
            wr(12'h094, 32'(sv));
            peek(12'h094, d); chk("R5 readback", d, 32'(sv));
            s_eff = (sv < 8) ? 8 : sv;
            wr(12'h000, 32'h0100_3900);
            time_first(k);
            chk("R4 R5 latency", k, s_eff + 61);
            wait_chain();
            clear_flags();
        end

        // R9: repeating mode, back-to-back chains, go cleared mid-chain
        wr(12'h094, 32'h8);
        wr(12'h0A4, 32'h5);
        log_n = 0;
        wr(12'h000, 32'h2100_3900);
        k = 0;
        while (log_n < 5 && k < 2000) begin @(negedge clk); k++; end
        wr(12'h000, 32'h2000_3900);
        repeat (400) @(negedge clk);
        chk("R9 stops after chain", log_n, 6);
        for (int i = 0; i < 6; i++) chk("R9 order", log_ch[i], (i % 2 == 1) ? 2 : 0);
        for (int i = 0; i < 5; i++) chk("R9 spacing", log_cyc[i+1] - log_cyc[i], 68);
        chk("R9 idle", {31'b0, conv_busy}, 32'h0);
        clear_flags();

        // R10: power-down blocks, release adds the warm-up hold
        wr(12'h0A4, 32'h1);
        log_n = 0;
        wr(12'h000, 32'h0100_3901);
        repeat (200) @(negedge clk);
        peek(12'h010, d); chk("R10 no chain in power-down", d, 32'h0);
        chk("R10 no result in power-down", log_n, 0);
        wr(12'h000, 32'h0100_3900);
        time_first(k);
        chk("R10 warm-up latency", k, 8 + 64);
        wait_chain();
        clear_flags();

        // R13 and R3: empty selection, upper selection bits read zero
        wr(12'h0A4, 32'hFFFF_FF00);
        peek(12'h0A4, d); chk("R3 upper bits zero", d, 32'h0);
        wr(12'h000, 32'h0100_3900);
        repeat (200) @(negedge clk);
        peek(12'h010, d); chk("R13 no chain", d, 32'h0);
        chk("R13 no irq", {31'b0, irq}, 32'h0);
        peek(12'h000, d); chk("R13 go stays", d, 32'h0100_3900);
        wr(12'h000, 32'h0000_3900);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule